// File: doc/BRIEF.md
# Mode-Dependent Multiplexed GPIO Port

This block is an eight-pin general-purpose I/O port. Its pins are shared with a system clock output and with the signals of an external bus controller. Software sees three registers on a simple register bus. The first is a write-only direction register. The second is a read/write output data register. The third is a read-only view of the pin state. A 2-bit operating mode decides which function owns each pin, and it also sets the reset value of the direction register.

In single-chip mode every pin is plain GPIO. In the three expanded modes the roles change:
- The top pin carries the system clock whenever its direction bit is set.
- The next four pins are bus-control outputs in all cases.
- Each of the three low pins is handed to the bus controller through its own enable, and stays GPIO otherwise.

The block has several reset and low-power inputs, and each one affects the registers differently. A power-on reset and hardware standby reload the direction register. A manual reset clears only the data register. Software standby leaves both registers alone but freezes or tri-states the pins that the bus controller owns.

Pin outputs and read data are registered. They change one clock after the inputs that cause them.

Top module: `muxport_top`

## Requirements
- R1: When `por` or `hw_stby` is high at a clock edge, the direction register loads 0x80 if `mode` is 0, 1 or 2 (expanded) and 0x00 if `mode` is 3 (single-chip). The same edge clears the data register, and `pin_oe`, `pin_out` and `bus_rdata` go to 0.
- R2: A cycle with `man_rst` high clears the data register and leaves the direction register unchanged. `sw_stby` changes neither register.
- R3: A write strobe loads the direction register at address 0xFE3E and the data register at address 0xFF0E. A write to the pin-state address 0xFFBE changes nothing, and so does any write during a reset cycle.
- R4: `bus_rdata` is registered. It shows the read result one cycle after `bus_rd`, and it is 0 in any cycle that follows no read. A read of the direction address returns 0xFF, a read of the data address returns the data register, and a read of an unmapped address returns 0x00.
- R5: For each bit, a read of the pin-state address returns the data register bit if that pin is a GPIO pin with its direction bit at 1. For every other pin it returns the level of `pin_in`, delayed through a 2-stage synchronizer.
- R6: In single-chip mode, `pin_oe` equals the direction register and `pin_out` equals the data register, one cycle later.
- R7: In expanded modes, pin 7 has `pin_out` equal to `sysclk_in` and `pin_oe` equal to direction bit 7.
- R8: In expanded modes, pins 6 to 3 have `pin_oe` at 1 and `pin_out` equal to `ctl_val[6:3]`, whatever their direction bits are.
- R9: In expanded modes, a low pin i (0 to 2) with `bc_en[i]` high takes `ctl_oe[i]` and `ctl_val[i]`. With `bc_en[i]` low, the pin is GPIO, driven from the direction and data registers.
- R10: While `sw_stby` is high, the pins that the bus controller owns behave as follows:
  - With `stby_hiz` low, they keep their last `pin_out` and `pin_oe`.
  - With `stby_hiz` high, they keep their last `pin_out` and drop `pin_oe` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| hw_stby | input | 1 | Hardware standby, acts like power-on reset |
| man_rst | input | 1 | Manual reset, clears data register only |
| sw_stby | input | 1 | Software standby |
| stby_hiz | input | 1 | Standby policy: 1 tri-states bus-owned pins |
| mode | input | 2 | Operating mode, 3 = single-chip, others expanded |
| bus_addr | input | 16 | Register address, low 16 bits |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| sysclk_in | input | 1 | System clock level for pin 7 |
| ctl_val | input | 7 | Bus-control output values for pins 6..0 |
| ctl_oe | input | 3 | Bus-controller output enables for pins 2..0 |
| bc_en | input | 3 | Bus-controller ownership of pins 2..0 |
| pin_in | input | 8 | External pin levels |
| pin_out | output | 8 | Registered pin output values |
| pin_oe | output | 8 | Registered pin output enables |

## Verification
The hardest situation to reach is software standby on an expanded-mode port in which the low pins have mixed owners. The bench has to show that only the pins the bus controller owns freeze or tri-state, while a GPIO neighbour and the clock pin keep following their own sources. To get there, the bench first programs a mixed `bc_en` and `ctl_oe` setting. It then changes `ctl_val` in the same cycle that standby is raised, so that a held value can be told apart from a live one. After that, it flips `stby_hiz`. A cycle-level behavioural model also follows a stretch of mixed random stimulus that includes reset pulses and mode changes.

// File: rtl/muxport_pkg.sv
package muxport_pkg;
  localparam logic [1:0] MODE_SINGLE = 2'd3;

  function automatic logic is_expanded(input logic [1:0] m);
    return m != MODE_SINGLE;
  endfunction
endpackage

// File: rtl/muxport_regs.sv
module muxport_regs
  import muxport_pkg::*;
#(
  parameter int W = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] DIR_ADDR = 16'hFE3E,
  parameter logic [AW-1:0] DAT_ADDR = 16'hFF0E,
  parameter logic [AW-1:0] PIN_ADDR = 16'hFFBE
) (
  input  logic          clk,
  input  logic          hard_rst,
  input  logic          man_rst,
  input  logic [1:0]    mode,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  dat_q
);
  localparam logic [W-1:0] DIR_EXP_INIT = {1'b1, {(W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (hard_rst) begin
      dir_q <= is_expanded(mode) ? DIR_EXP_INIT : '0;
      dat_q <= '0;
    end else if (man_rst) begin
      dat_q <= '0;
    end else if (wr) begin
      if (addr == DIR_ADDR) dir_q <= wdata;
      if (addr == DAT_ADDR) dat_q <= wdata;
    end
  end

  assert_reset_value_R1: assert property (@(posedge clk) disable iff (hard_rst)
    $fell(hard_rst) |-> (dat_q == '0 &&
      dir_q == (is_expanded($past(mode)) ? DIR_EXP_INIT : '0)));

  assert_manual_keeps_dir_R2: assert property (@(posedge clk) disable iff (hard_rst)
    man_rst |=> (dir_q == $past(dir_q) && dat_q == '0));

  assert_pin_addr_write_ignored_R3: assert property (@(posedge clk) disable iff (hard_rst)
    (wr && !man_rst && addr == PIN_ADDR) |=>
      (dir_q == $past(dir_q) && dat_q == $past(dat_q)));
endmodule

// File: rtl/muxport_sync.sv
module muxport_sync #(
  parameter int W = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= (s == 0) ? d : stage[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/muxport_route.sv
module muxport_route
  import muxport_pkg::*;
#(
  parameter int W = 8,
  parameter int NLO = 3
) (
  input  logic [1:0]   mode,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] dat_q,
  input  logic         sysclk_in,
  input  logic [W-2:0] ctl_val,
  input  logic [NLO-1:0] ctl_oe,
  input  logic [NLO-1:0] bc_en,
  input  logic         sw_stby,
  input  logic         stby_hiz,
  input  logic [W-1:0] prev_out,
  input  logic [W-1:0] prev_oe,
  output logic [W-1:0] nxt_out,
  output logic [W-1:0] nxt_oe,
  output logic [W-1:0] gpio_own
);
  logic expd;
  assign expd = is_expanded(mode);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic out_b, oe_b, gp_b;
    if (i == W-1) begin : g_clk
      always_comb begin
        if (expd) begin
          gp_b  = 1'b0;
          oe_b  = dir_q[i];
          out_b = sysclk_in;
        end else begin
          gp_b  = 1'b1;
          oe_b  = dir_q[i];
          out_b = dat_q[i];
        end
      end
    end else begin : g_shared
      logic bus_own, bus_oe;
      if (i >= NLO) begin : g_hi
        assign bus_own = expd;
        assign bus_oe  = 1'b1;
      end else begin : g_lo
        assign bus_own = expd & bc_en[i];
        assign bus_oe  = ctl_oe[i];
      end
      always_comb begin
        gp_b = !bus_own;
        if (!bus_own) begin
          oe_b  = dir_q[i];
          out_b = dat_q[i];
        end else if (sw_stby) begin
          oe_b  = stby_hiz ? 1'b0 : prev_oe[i];
          out_b = prev_out[i];
        end else begin
          oe_b  = bus_oe;
          out_b = ctl_val[i];
        end
      end
    end
    assign nxt_out[i]  = out_b;
    assign nxt_oe[i]   = oe_b;
    assign gpio_own[i] = gp_b;
  end
endmodule

// File: rtl/muxport_top.sv
module muxport_top
  import muxport_pkg::*;
#(
  parameter int W = 8,
  parameter int NLO = 3,
  parameter int AW = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [AW-1:0] DIR_ADDR = 16'hFE3E,
  parameter logic [AW-1:0] DAT_ADDR = 16'hFF0E,
  parameter logic [AW-1:0] PIN_ADDR = 16'hFFBE
) (
  input  logic           clk,
  input  logic           por,
  input  logic           hw_stby,
  input  logic           man_rst,
  input  logic           sw_stby,
  input  logic           stby_hiz,
  input  logic [1:0]     mode,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [W-1:0]   bus_wdata,
  output logic [W-1:0]   bus_rdata,
  input  logic           sysclk_in,
  input  logic [W-2:0]   ctl_val,
  input  logic [NLO-1:0] ctl_oe,
  input  logic [NLO-1:0] bc_en,
  input  logic [W-1:0]   pin_in,
  output logic [W-1:0]   pin_out,
  output logic [W-1:0]   pin_oe
);
  logic hard_rst;
  logic [W-1:0] dir_q, dat_q, sync_q, nxt_out, nxt_oe, gpio_own, gp_drive, pin_state;

  assign hard_rst = por | hw_stby;

  muxport_regs #(.W(W), .AW(AW), .DIR_ADDR(DIR_ADDR), .DAT_ADDR(DAT_ADDR),
                 .PIN_ADDR(PIN_ADDR)) u_regs (
    .clk(clk), .hard_rst(hard_rst), .man_rst(man_rst), .mode(mode),
    .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .dir_q(dir_q), .dat_q(dat_q)
  );

  muxport_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(hard_rst), .d(pin_in), .q(sync_q)
  );

  muxport_route #(.W(W), .NLO(NLO)) u_route (
    .mode(mode), .dir_q(dir_q), .dat_q(dat_q), .sysclk_in(sysclk_in),
    .ctl_val(ctl_val), .ctl_oe(ctl_oe), .bc_en(bc_en),
    .sw_stby(sw_stby), .stby_hiz(stby_hiz),
    .prev_out(pin_out), .prev_oe(pin_oe),
    .nxt_out(nxt_out), .nxt_oe(nxt_oe), .gpio_own(gpio_own)
  );

  assign gp_drive  = gpio_own & dir_q;
  assign pin_state = (gp_drive & dat_q) | (~gp_drive & sync_q);

  always_ff @(posedge clk) begin
    if (hard_rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else begin
      pin_out <= nxt_out;
      pin_oe  <= nxt_oe;
    end
  end

  always_ff @(posedge clk) begin
    if (hard_rst || !bus_rd) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        DIR_ADDR: bus_rdata <= '1;
        DAT_ADDR: bus_rdata <= dat_q;
        PIN_ADDR: bus_rdata <= pin_state;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assert_dir_reads_ones_R4: assert property (@(posedge clk) disable iff (hard_rst)
    (bus_rd && bus_addr == DIR_ADDR) |=> bus_rdata == '1);

  assert_no_read_zero_R4: assert property (@(posedge clk) disable iff (hard_rst)
    !bus_rd |=> bus_rdata == '0);

  assert_single_chip_dir_R6: assert property (@(posedge clk) disable iff (hard_rst)
    (mode == MODE_SINGLE) |=> pin_oe == $past(dir_q));

  assert_bus_pins_drive_R8: assert property (@(posedge clk) disable iff (hard_rst)
    (is_expanded(mode) && !sw_stby) |=> pin_oe[W-2:NLO] == '1);

  assert_clock_pin_R7: assert property (@(posedge clk) disable iff (hard_rst)
    is_expanded(mode) |=> pin_out[W-1] == $past(sysclk_in));

  assert_standby_hiz_R10: assert property (@(posedge clk) disable iff (hard_rst)
    (is_expanded(mode) && sw_stby && stby_hiz) |=> pin_oe[W-2:NLO] == '0);

  assert_standby_hold_R10: assert property (@(posedge clk) disable iff (hard_rst)
    (is_expanded(mode) && sw_stby) |=> $stable(pin_out[W-2:NLO]));
endmodule

// File: tb/tb_muxport_top.sv
`timescale 1ns/1ps
module tb_muxport_top;
  logic clk = 1'b0;
  logic por = 1'b1, hw_stby = 1'b0, man_rst = 1'b0, sw_stby = 1'b0, stby_hiz = 1'b0;
  logic [1:0] mode = 2'd3;
  logic [15:0] bus_addr = 16'h0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h0;
  logic [7:0] bus_rdata;
  logic sysclk_in = 1'b0;
  logic [6:0] ctl_val = 7'h0;
  logic [2:0] ctl_oe = 3'h0, bc_en = 3'h0;
  logic [7:0] pin_in = 8'h0;
  logic [7:0] pin_out, pin_oe;

  int checks = 0, errors = 0, cycles = 0;
  bit cmp_en = 0;

  localparam logic [15:0] A_DIR = 16'hFE3E, A_DAT = 16'hFF0E, A_PIN = 16'hFFBE;

  always #2.5 clk = ~clk;

  muxport_top dut (
    .clk(clk), .por(por), .hw_stby(hw_stby), .man_rst(man_rst), .sw_stby(sw_stby),
    .stby_hiz(stby_hiz), .mode(mode), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sysclk_in(sysclk_in), .ctl_val(ctl_val), .ctl_oe(ctl_oe), .bc_en(bc_en),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Behavioural reference model
  logic [7:0] m_dir = 8'h0, m_dat = 8'h0, m_s0 = 8'h0, m_s1 = 8'h0;
  logic [7:0] e_out = 8'h0, e_oe = 8'h0, e_rd = 8'h0;

  always @(posedge clk) begin
    logic hard, expd, bus_own, gp;
    logic [7:0] n_out, n_oe, n_rd, ps;
    hard = por | hw_stby;
    expd = (mode != 2'd3);
    n_out = 8'h0; n_oe = 8'h0; n_rd = 8'h0; ps = 8'h0;
    for (int i = 0; i < 8; i++) begin
      bus_own = expd && ((i >= 3 && i <= 6) || (i < 3 && bc_en[i]));
      gp = !expd || (i < 3 && !bc_en[i]);
      ps[i] = (gp && m_dir[i]) ? m_dat[i] : m_s1[i];
      if (expd && i == 7) begin
        n_oe[i] = m_dir[7]; n_out[i] = sysclk_in;
      end else if (bus_own) begin
        if (sw_stby) begin
          n_oe[i] = stby_hiz ? 1'b0 : e_oe[i]; n_out[i] = e_out[i];
        end else begin
          n_oe[i] = (i >= 3) ? 1'b1 : ctl_oe[i]; n_out[i] = ctl_val[i];
        end
      end else begin
        n_oe[i] = m_dir[i]; n_out[i] = m_dat[i];
      end
    end
    if (bus_rd) begin
      if (bus_addr == A_DIR) n_rd = 8'hFF;
      else if (bus_addr == A_DAT) n_rd = m_dat;
      else if (bus_addr == A_PIN) n_rd = ps;
    end
    if (hard) begin
      e_out = 8'h0; e_oe = 8'h0; e_rd = 8'h0;
      m_s1 = 8'h0; m_s0 = 8'h0;
      m_dir = expd ? 8'h80 : 8'h00; m_dat = 8'h0;
    end else begin
      e_out = n_out; e_oe = n_oe; e_rd = n_rd;
      m_s1 = m_s0; m_s0 = pin_in;
      if (man_rst) m_dat = 8'h0;
      else if (bus_wr) begin
        if (bus_addr == A_DIR) m_dir = bus_wdata;
        if (bus_addr == A_DAT) m_dat = bus_wdata;
      end
    end
    cmp_en = 1;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(mode == 2'd3 ? "R6 model pin_out" : "R8 model pin_out", pin_out, e_out);
      chk(mode == 2'd3 ? "R6 model pin_oe" : "R9 model pin_oe", pin_oe, e_oe);
      chk("R4 model bus_rdata", bus_rdata, e_rd);
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    por = 1'b0;
    @(negedge clk);
    chk("R1 single-chip reset oe", pin_oe, 8'h00);

    wr_reg(A_DIR, 8'hA5);
    wr_reg(A_DAT, 8'h3C);
    @(negedge clk);
    chk("R6 oe follows dir", pin_oe, 8'hA5);
    chk("R6 out follows data", pin_out, 8'h3C);
    rd_reg(A_DAT, rv); chk("R4 data read", rv, 8'h3C);
    rd_reg(A_DIR, rv); chk("R4 dir read ones", rv, 8'hFF);
    rd_reg(16'h1234, rv); chk("R4 unmapped read", rv, 8'h00);

    pin_in = 8'h0F;
    repeat (3) @(negedge clk);
    rd_reg(A_PIN, rv); chk("R5 pin state mix", rv, 8'h2E);

    wr_reg(A_PIN, 8'hFF);
    @(negedge clk);
    chk("R3 pin addr write ignored out", pin_out, 8'h3C);
    chk("R3 pin addr write ignored oe", pin_oe, 8'hA5);

    man_rst = 1'b1; @(negedge clk); man_rst = 1'b0; @(negedge clk);
    chk("R2 manual reset clears data", pin_out, 8'h00);
    chk("R2 manual reset keeps dir", pin_oe, 8'hA5);

    man_rst = 1'b1; wr_reg(A_DAT, 8'h55); man_rst = 1'b0; @(negedge clk);
    chk("R3 write during reset ignored", pin_out, 8'h00);

    sw_stby = 1'b1; wr_reg(A_DAT, 8'h11); @(negedge clk);
    chk("R2 sw standby keeps regs single-chip", pin_out, 8'h11);
    sw_stby = 1'b0;

    hw_stby = 1'b1; @(negedge clk);
    chk("R1 hw standby drops oe", pin_oe, 8'h00);
    @(negedge clk); hw_stby = 1'b0; @(negedge clk);
    chk("R1 hw standby single-chip dir", pin_oe, 8'h00);

    mode = 2'd1; sysclk_in = 1'b1; ctl_val = 7'h55;
    por = 1'b1; repeat (2) @(negedge clk); por = 1'b0; @(negedge clk);
    chk("R7 expanded reset oe", pin_oe, 8'hF8);
    chk("R7 R8 expanded out", pin_out, 8'hD0);

    wr_reg(A_DIR, 8'h07);
    wr_reg(A_DAT, 8'h02);
    @(negedge clk);
    chk("R8 bus pins ignore dir", pin_oe, 8'h7F);
    chk("R7 clock pin out with dir 0", pin_out, 8'hD2);

    bc_en = 3'b101; ctl_oe = 3'b001; @(negedge clk);
    chk("R9 mixed low owners oe", pin_oe, 8'h7B);
    chk("R9 mixed low owners out", pin_out, 8'hD7);

    sw_stby = 1'b1; stby_hiz = 1'b0; ctl_val = 7'h2A; @(negedge clk);
    chk("R10 standby hold out", pin_out, 8'hD7);
    chk("R10 standby hold oe", pin_oe, 8'h7B);
    stby_hiz = 1'b1; @(negedge clk);
    chk("R10 standby hiz oe", pin_oe, 8'h02);
    chk("R10 standby hiz out held", pin_out, 8'hD7);
    sw_stby = 1'b0; stby_hiz = 1'b0; @(negedge clk);
    chk("R9 after standby out", pin_out, 8'hAA);
    chk("R9 after standby oe", pin_oe, 8'h7B);
    sysclk_in = 1'b0; @(negedge clk);
    chk("R7 clock level follows", pin_out, 8'h2A);

    hw_stby = 1'b1; repeat (2) @(negedge clk); hw_stby = 1'b0; @(negedge clk);
    chk("R1 hw standby expanded dir", pin_oe, 8'hF9);

    for (int k = 0; k < 600; k++) begin
      logic [2:0] sel;
      sel = 3'($urandom_range(0, 3));
      bus_addr = (sel == 0) ? A_DIR : (sel == 1) ? A_DAT : (sel == 2) ? A_PIN : 16'h0100;
      bus_wr = 1'($urandom_range(0, 1)); bus_rd = 1'($urandom_range(0, 1));
      bus_wdata = 8'($urandom); pin_in = 8'($urandom);
      ctl_val = 7'($urandom); ctl_oe = 3'($urandom); bc_en = 3'($urandom);
      sysclk_in = 1'($urandom); sw_stby = ($urandom_range(0, 7) == 0);
      stby_hiz = 1'($urandom); man_rst = ($urandom_range(0, 15) == 0);
      por = ($urandom_range(0, 40) == 0); hw_stby = ($urandom_range(0, 60) == 0);
      if ($urandom_range(0, 30) == 0) mode = 2'($urandom);
      @(negedge clk);
    end
    por = 1'b0; hw_stby = 1'b0; man_rst = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule